// File: doc/BRIEF.md
# DMA Channel Request Arbiter and Control Bank

This block sits in front of the transfer engine of a 21-channel DMA controller. It keeps the per-channel control bits: enable, high priority, burst-only, request mask, alternate structure select and completion routing mask. Software changes each of these bits through a pair of write-one-to-set and write-one-to-clear offsets on a simple register port. Peripherals present single and burst request lines per channel, and software can raise one-shot requests of its own. The block picks one requesting channel and grants it to the engine. It holds that grant until the engine ends the arbitration chunk. When the engine reports that a channel's whole transfer is finished, the block turns off that channel's enable and records completion.

Completion is reported in one of two places. By default a one-cycle pulse goes back to the owning peripheral. When the channel's routing mask bit is set, completion is instead collected into a single software interrupt. A master enable gates all new grants. A sticky bus-error flag, cleared by writing one, reflects error reports from the engine.

Top module: `dmarb_ctrl`

## Requirements
- R1: Register offsets on `reg_addr_i`: 0 config (bit 0 master enable, written directly), 1/2 enable set/clear, 3/4 priority set/clear, 5/6 burst-only set/clear, 7/8 request-mask set/clear, 9/10 alternate-select set/clear, 11 software request, 12 done status, 13/14 done-mask set/clear, 15 error (bit 0). On a set or clear offset, each data bit written as 1 sets or clears that channel's bit, and bits written as 0 leave it unchanged. Reading either offset of a pair returns the current bits. The read data is combinational from the address and the current state.
- R2: A write to offset 11 marks the channels whose data bits are 1 as pending. At each clock edge the next pending bit is (pending OR written bit) AND the channel's enable before that edge AND NOT granted at that edge. Offset 11 reads back the pending bits.
- R3: A channel is eligible when it is enabled and either it has a pending software request, or its request-mask bit is 0 and either `hw_breq_i` is high, or `hw_req_i` is high while its burst-only bit is 0.
- R4: Among eligible channels, those with the priority bit set win over the rest. Within one level, the lowest channel number wins.
- R5: A new grant is taken only when no grant is held. It appears on `grant_valid_o`/`grant_ch_o` after the edge at which it was taken. It stays stable until an edge with `eng_chunk_done_i` high, after which `grant_valid_o` is low for at least one cycle. `grant_alt_o` shows the granted channel's alternate-select bit.
- R6: At an edge where a grant is held and both `eng_chunk_done_i` and `eng_xfer_done_i` are high, the granted channel's enable is cleared and its done bit is set. An enable set write in the same cycle takes precedence over this clear.
- R7: On completion, if the channel's done-mask bit is 0, `periph_done_o` pulses that channel's bit for one cycle after the edge. `sw_done_irq_o` is high whenever any channel has both its done bit and its done-mask bit set.
- R8: Writing 1 to a bit of offset 12 clears that done bit. A completion in the same cycle sets it anyway.
- R9: No new grant is taken while the master enable is 0.
- R10: `eng_bus_err_i` sets a sticky error flag, shown on `err_irq_o` and on bit 0 of offset 15. Writing 1 to bit 0 of offset 15 clears the flag unless a new error arrives in the same cycle.
- R11: After reset, every control bit, pending bit, done bit, the master enable, the error flag and the grant are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 21 | Write data, one bit per channel |
| reg_rdata_o | output | 21 | Read data for `reg_addr_i` |
| hw_req_i | input | 21 | Peripheral single requests |
| hw_breq_i | input | 21 | Peripheral burst requests |
| eng_chunk_done_i | input | 1 | Engine finished the current arbitration chunk |
| eng_xfer_done_i | input | 1 | Qualifies chunk end as end of the whole transfer |
| eng_bus_err_i | input | 1 | Engine saw a bus error |
| grant_valid_o | output | 1 | A channel is granted |
| grant_ch_o | output | 5 | Granted channel number |
| grant_alt_o | output | 1 | Alternate-select bit of the granted channel |
| periph_done_o | output | 21 | One-cycle completion pulse per channel to peripherals |
| sw_done_irq_o | output | 1 | Combined software completion interrupt |
| err_irq_o | output | 1 | Sticky bus-error flag |

## Verification
Several properties are checked on every cycle by assertions. A held grant keeps its channel until the chunk ends. A grant never starts while the master enable was off. A completing channel is seen done with its enable cleared on the next cycle. A peripheral pulse never appears without the matching done bit. The error flag only rises after an engine error report. The priority order between levels and within a level, the mask and burst-only filtering, discarding of software requests on disabled channels, and the set-over-clear races on the done and enable bits can only be shown by the bench's directed scenarios and its long mixed random run. In both, a behavioural model predicts every output every cycle.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int unsigned NUM_CH = 21;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFF_CFG     = 4'd0,
    OFF_SWREQ   = 4'd11,
    OFF_DONE    = 4'd12,
    OFF_ERR     = 4'd15
  } reg_off_e;

  // attribute a uses set offset 1+2a / clear offset 2+2a, except done mask
  localparam int unsigned ATTR_EN  = 0;
  localparam int unsigned ATTR_PRI = 1;
  localparam int unsigned ATTR_BO  = 2;
  localparam int unsigned ATTR_MSK = 3;
  localparam int unsigned ATTR_ALT = 4;
  localparam int unsigned ATTR_DMK = 5;
  localparam int unsigned NUM_ATTR = 6;

  function automatic logic [ADDR_W-1:0] attr_set_off(int unsigned a);
    return (a == ATTR_DMK) ? ADDR_W'(13) : ADDR_W'(1 + 2 * a);
  endfunction

  function automatic logic [ADDR_W-1:0] attr_clr_off(int unsigned a);
    return (a == ATTR_DMK) ? ADDR_W'(14) : ADDR_W'(2 + 2 * a);
  endfunction
endpackage

// File: rtl/dmarb_bitbank.sv
module dmarb_bitbank #(
  parameter int unsigned W = 21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_m, clr_m;

  assign set_m = {W{set_i}} & wdata_i;
  assign clr_m = ({W{clr_i}} & wdata_i) | hw_clr_i;

  // set wins over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_m) | set_m;
  end
endmodule

// File: rtl/dmarb_pick.sv
module dmarb_pick #(
  parameter int unsigned W  = 21,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dmarb_grant.sv
module dmarb_grant #(
  parameter int unsigned NCH = 21,
  parameter int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] elig_i,
  input  logic [NCH-1:0] pri_i,
  input  logic           master_en_i,
  input  logic           chunk_done_i,
  input  logic           xfer_done_i,
  output logic           grant_valid_o,
  output logic [CHW-1:0] grant_ch_o,
  output logic [NCH-1:0] take_o,
  output logic [NCH-1:0] cpl_o
);
  logic           hi_any, lo_any, start;
  logic [CHW-1:0] hi_idx, lo_idx, sel;

  dmarb_pick #(.W(NCH), .IW(CHW)) u_pick_hi (
    .req_i(elig_i & pri_i), .any_o(hi_any), .idx_o(hi_idx)
  );
  dmarb_pick #(.W(NCH), .IW(CHW)) u_pick_lo (
    .req_i(elig_i), .any_o(lo_any), .idx_o(lo_idx)
  );

  assign sel    = hi_any ? hi_idx : lo_idx;
  assign start  = !grant_valid_o && master_en_i && lo_any;
  assign take_o = start ? (NCH'(1) << sel) : '0;
  assign cpl_o  = (grant_valid_o && chunk_done_i && xfer_done_i) ?
                  (NCH'(1) << grant_ch_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_ch_o    <= '0;
    end else if (grant_valid_o) begin
      if (chunk_done_i) grant_valid_o <= 1'b0;
    end else if (start) begin
      grant_valid_o <= 1'b1;
      grant_ch_o    <= sel;
    end
  end

  assert_grant_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !chunk_done_i) |=> (grant_valid_o && $stable(grant_ch_o)));

  assert_master_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> $past(master_en_i));
endmodule

// File: rtl/dmarb_ctrl.sv
module dmarb_ctrl
  import dmarb_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned AW  = ADDR_W,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [NCH-1:0] reg_wdata_i,
  output logic [NCH-1:0] reg_rdata_o,
  input  logic [NCH-1:0] hw_req_i,
  input  logic [NCH-1:0] hw_breq_i,
  input  logic           eng_chunk_done_i,
  input  logic           eng_xfer_done_i,
  input  logic           eng_bus_err_i,
  output logic           grant_valid_o,
  output logic [CHW-1:0] grant_ch_o,
  output logic           grant_alt_o,
  output logic [NCH-1:0] periph_done_o,
  output logic           sw_done_irq_o,
  output logic           err_irq_o
);
  logic [NUM_ATTR-1:0][NCH-1:0] attr_q;
  logic [NCH-1:0] swpend_q, done_q, elig, take, cpl;
  logic           master_q, err_q;
  logic [NCH-1:0] en, pri, bo, msk, alt, dmk;

  assign en  = attr_q[ATTR_EN];
  assign pri = attr_q[ATTR_PRI];
  assign bo  = attr_q[ATTR_BO];
  assign msk = attr_q[ATTR_MSK];
  assign alt = attr_q[ATTR_ALT];
  assign dmk = attr_q[ATTR_DMK];

  for (genvar a = 0; a < NUM_ATTR; a++) begin : g_attr
    logic [NCH-1:0] hw_clr;
    if (a == ATTR_EN) begin : g_auto_clr
      assign hw_clr = cpl;
    end else begin : g_no_clr
      assign hw_clr = '0;
    end
    dmarb_bitbank #(.W(NCH)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (reg_we_i && reg_addr_i == AW'(attr_set_off(a))),
      .clr_i   (reg_we_i && reg_addr_i == AW'(attr_clr_off(a))),
      .wdata_i (reg_wdata_i),
      .hw_clr_i(hw_clr),
      .q_o     (attr_q[a])
    );
  end

  logic wr_cfg, wr_sw, wr_done, wr_err;
  assign wr_cfg  = reg_we_i && reg_addr_i == AW'(OFF_CFG);
  assign wr_sw   = reg_we_i && reg_addr_i == AW'(OFF_SWREQ);
  assign wr_done = reg_we_i && reg_addr_i == AW'(OFF_DONE);
  assign wr_err  = reg_we_i && reg_addr_i == AW'(OFF_ERR);

  assign elig = en & (swpend_q | (~msk & (hw_breq_i | (~bo & hw_req_i))));

  dmarb_grant #(.NCH(NCH), .CHW(CHW)) u_grant (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .elig_i       (elig),
    .pri_i        (pri),
    .master_en_i  (master_q),
    .chunk_done_i (eng_chunk_done_i),
    .xfer_done_i  (eng_xfer_done_i),
    .grant_valid_o(grant_valid_o),
    .grant_ch_o   (grant_ch_o),
    .take_o       (take),
    .cpl_o        (cpl)
  );

  assign grant_alt_o = alt[grant_ch_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swpend_q      <= '0;
      done_q        <= '0;
      periph_done_o <= '0;
      master_q      <= 1'b0;
      err_q         <= 1'b0;
    end else begin
      swpend_q      <= (swpend_q | ({NCH{wr_sw}} & reg_wdata_i)) & en & ~take;
      done_q        <= (done_q & ~({NCH{wr_done}} & reg_wdata_i)) | cpl;
      periph_done_o <= cpl & ~dmk;
      if (wr_cfg) master_q <= reg_wdata_i[0];
      err_q         <= (err_q & ~(wr_err && reg_wdata_i[0])) | eng_bus_err_i;
    end
  end

  assign sw_done_irq_o = |(done_q & dmk);
  assign err_irq_o     = err_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(OFF_CFG):   reg_rdata_o[0] = master_q;
      AW'(OFF_SWREQ): reg_rdata_o    = swpend_q;
      AW'(OFF_DONE):  reg_rdata_o    = done_q;
      AW'(OFF_ERR):   reg_rdata_o[0] = err_q;
      default: begin
        for (int a = 0; a < NUM_ATTR; a++) begin
          if (reg_addr_i == AW'(attr_set_off(a)) || reg_addr_i == AW'(attr_clr_off(a)))
            reg_rdata_o = attr_q[a];
        end
      end
    endcase
  end

  assert_done_on_cpl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cpl) |=> ((done_q & $past(cpl)) == $past(cpl)));

  assert_en_off_on_cpl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cpl) && !(reg_we_i && reg_addr_i == AW'(attr_set_off(ATTR_EN))))
      |=> ((en & $past(cpl)) == '0));

  assert_pulse_has_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((periph_done_o & ~done_q) == '0));

  assert_err_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(eng_bus_err_i));
endmodule

// File: tb/dmarb_ctrl_tb.sv
module dmarb_ctrl_tb_top;
  localparam int NCH = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            reg_we = 1'b0;
  logic [3:0]      reg_addr = '0;
  logic [NCH-1:0]  reg_wdata = '0, hw_req = '0, hw_breq = '0;
  logic            chunk = 1'b0, xfer = 1'b0, berr = 1'b0;
  logic [NCH-1:0]  rdata, pdone;
  logic            gv, galt, sirq, eirq;
  logic [4:0]      gch;

  dmarb_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .hw_req_i(hw_req),
    .hw_breq_i(hw_breq), .eng_chunk_done_i(chunk), .eng_xfer_done_i(xfer),
    .eng_bus_err_i(berr), .grant_valid_o(gv), .grant_ch_o(gch),
    .grant_alt_o(galt), .periph_done_o(pdone), .sw_done_irq_o(sirq),
    .err_irq_o(eirq)
  );

  // behavioural reference: attributes indexed 0 en,1 pri,2 burst-only,3 mask,4 alt,5 done mask
  bit [NCH-1:0] m_attr [6];
  bit [NCH-1:0] m_swp, m_done, m_pd;
  bit           m_master, m_err, m_gv;
  int           m_gch;

  function automatic bit m_elig(int c);
    return m_attr[0][c] && (m_swp[c] || (!m_attr[3][c] &&
           (hw_breq[c] || (!m_attr[2][c] && hw_req[c]))));
  endfunction

  function automatic int set_off(int a);
    return (a == 5) ? 13 : 1 + 2 * a;
  endfunction

  function automatic logic [NCH-1:0] m_read(int addr);
    if (addr == 0) return NCH'(m_master);
    if (addr == 11) return m_swp;
    if (addr == 12) return m_done;
    if (addr == 15) return NCH'(m_err);
    for (int a = 0; a < 6; a++)
      if (addr == set_off(a) || addr == set_off(a) + 1) return m_attr[a];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 6; a++) m_attr[a] = '0;
      m_swp = '0; m_done = '0; m_pd = '0;
      m_master = 0; m_err = 0; m_gv = 0; m_gch = 0;
    end else begin
      int tk, cp;
      bit [NCH-1:0] na [6];
      bit [NCH-1:0] en_old;
      tk = -1; cp = -1;
      if (!m_gv && m_master) begin
        for (int c = 0; c < NCH; c++) if (tk < 0 && m_elig(c) && m_attr[1][c]) tk = c;
        for (int c = 0; c < NCH; c++) if (tk < 0 && m_elig(c)) tk = c;
      end
      if (m_gv && chunk && xfer) cp = m_gch;
      en_old = m_attr[0];
      for (int a = 0; a < 6; a++) begin
        na[a] = m_attr[a];
        for (int c = 0; c < NCH; c++) begin
          if (reg_we && reg_addr == set_off(a) + 1 && reg_wdata[c]) na[a][c] = 0;
          if (a == 0 && c == cp) na[a][c] = 0;
          if (reg_we && reg_addr == set_off(a) && reg_wdata[c]) na[a][c] = 1;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        m_swp[c] = (m_swp[c] || (reg_we && reg_addr == 11 && reg_wdata[c]))
                   && en_old[c] && c != tk;
        if (reg_we && reg_addr == 12 && reg_wdata[c]) m_done[c] = 0;
        if (c == cp) m_done[c] = 1;
        m_pd[c] = (c == cp) && !m_attr[5][c];
      end
      for (int a = 0; a < 6; a++) m_attr[a] = na[a];
      if (reg_we && reg_addr == 0) m_master = reg_wdata[0];
      if (reg_we && reg_addr == 15 && reg_wdata[0]) m_err = 0;
      if (berr) m_err = 1;
      if (m_gv) begin
        if (chunk) m_gv = 0;
      end else if (tk >= 0) begin
        m_gv = 1; m_gch = tk;
      end
    end
  end

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string phase = "R11 reset";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R5 grant_valid", 32'(gv), 32'(m_gv));
    if (m_gv) begin
      chk("R4 grant_ch", 32'(gch), 32'(m_gch));
      chk("R5 grant_alt", 32'(galt), 32'(m_attr[4][m_gch]));
    end
    chk("R7 periph_done", 32'(pdone), 32'(m_pd));
    chk("R7 sw_done_irq", 32'(sirq), 32'(|(m_done & m_attr[5])));
    chk("R10 err_irq", 32'(eirq), 32'(m_err));
    chk("R1 rdata", 32'(rdata), 32'(m_read(int'(reg_addr))));
  endtask

  task automatic wr(int addr, logic [NCH-1:0] d);
    reg_we = 1; reg_addr = 4'(addr); reg_wdata = d;
    tick();
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic look(int addr, int n);
    reg_addr = 4'(addr);
    repeat (n) tick();
  endtask

  task automatic end_chunk(bit whole);
    chunk = 1; xfer = whole;
    tick();
    chunk = 0; xfer = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_bad++;
      $display("FAIL [watchdog] run did not end: actual %0d expected 0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int a = 0; a < 16; a++) look(a, 1);

    phase = "R1 set/clear";
    wr(1, 21'h5); look(1, 1); wr(1, '0); look(2, 1);
    wr(2, 21'h1); look(1, 1); wr(2, '0); look(1, 1);
    for (int a = 3; a <= 14; a += 2) begin
      if (a == 11) continue;
      wr(a, 21'h12345); look(a, 1); wr(a + 1, 21'h00345); look(a, 1);
    end
    wr(10, '1); wr(8, '1); wr(6, '1); wr(4, '1); wr(14, '1); wr(2, '1);

    phase = "R9 master gate";
    wr(1, 21'h8); wr(11, 21'h8); look(11, 4);
    wr(0, 21'h1); look(11, 3);

    phase = "R5 hold";
    hw_req = 21'h11; look(1, 5);
    end_chunk(0); look(1, 3);
    end_chunk(0); look(1, 2);

    phase = "R6 completion";
    wr(9, 21'h1); end_chunk(1); look(12, 3);
    hw_req = '0; look(1, 2);
    end_chunk(1); look(12, 2);

    phase = "R8 done w1c";
    wr(12, 21'h1); look(12, 2);

    phase = "R3 mask/burst";
    wr(1, 21'h60); wr(7, 21'h20); wr(5, 21'h40);
    hw_req = 21'h60; look(1, 4);
    hw_breq = 21'h20; look(1, 3);
    hw_breq = 21'h40; look(1, 3);
    end_chunk(1); hw_req = '0; hw_breq = '0; look(1, 3);
    wr(8, '1); wr(6, '1);

    phase = "R4 priority";
    wr(1, 21'h1A4); wr(3, 21'h80); hw_req = 21'h1A4; look(1, 2);
    end_chunk(1); look(1, 2); end_chunk(1); look(1, 2);
    end_chunk(1); look(1, 2); end_chunk(1); look(1, 2);
    hw_req = '0; wr(4, '1);

    phase = "R7 done mask";
    wr(13, 21'h400); wr(1, 21'hC00); hw_req = 21'hC00; look(12, 2);
    end_chunk(1); look(12, 2); end_chunk(1); look(12, 2);
    hw_req = '0;
    wr(12, 21'h400); look(12, 2);

    phase = "R8 set wins";
    wr(1, 21'h2); hw_req = 21'h2; look(12, 2);
    reg_we = 1; reg_addr = 4'd12; reg_wdata = 21'h2; chunk = 1; xfer = 1;
    tick(); reg_we = 0; chunk = 0; xfer = 0; hw_req = '0; look(12, 2);

    phase = "R2 sw pending";
    wr(11, 21'h4000); look(11, 2);
    wr(1, 21'h4000); wr(0, 21'h0); wr(11, 21'h4000); look(11, 2);
    wr(2, 21'h4000); look(11, 2);
    wr(1, 21'h4000); wr(11, 21'h4000); wr(0, 21'h1); look(11, 3);
    end_chunk(1); look(11, 2);

    phase = "R10 bus error";
    berr = 1; tick(); berr = 0; look(15, 2);
    reg_we = 1; reg_addr = 4'd15; reg_wdata = 21'h1; berr = 1;
    tick(); reg_we = 0; berr = 0; look(15, 1);
    wr(15, 21'h1); look(15, 2);

    phase = "R4 R5 R6 mixed";
    for (int i = 0; i < 6000; i++) begin
      reg_we = ($urandom % 4) == 0;
      reg_addr = 4'($urandom % 16);
      reg_wdata = NCH'($urandom);
      if (reg_addr == 0) reg_wdata[0] = ($urandom % 4) != 0;
      if (reg_addr == 2 || reg_addr == 12) reg_wdata = reg_wdata & NCH'($urandom);
      hw_req = NCH'($urandom) & NCH'($urandom);
      hw_breq = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      chunk = ($urandom % 3) == 0;
      xfer = $urandom % 2;
      berr = ($urandom % 16) == 0;
      tick();
    end
    reg_we = 0; chunk = 0; xfer = 0; berr = 0; look(12, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule